// File: doc/BRIEF.md
# Stall-Only Five-Stage Pipelined Core

This block is a small in-order processor. Each instruction passes through five stages in a fixed order: fetch, decode, memory read, execute and write-back. The instruction set has loads, stores, five three-operand ALU operations, an unconditional jump and two conditional branches that test one register for zero. There are no forwarding paths and no prediction. A register read-after-write dependence holds the younger instruction in decode until its producer reaches write-back. A control transfer stops fetch until the execute stage has resolved the outcome. The only exception to the no-forwarding rule is that the register file returns a value on the same cycle it is written.

The program and data memories are internal, with 64 words each. Both are loaded through ports while reset is held. Once reset is released the core runs from address 0. It raises `halt` when an END instruction has completed write-back. A free-running cycle counter and a retired-instruction counter stop at that point, so a bench can compare them with a timing chart worked out by hand. After halt, the data memory can be read back through the same port.

Fetch is controlled by a three-state machine:
- `FS_RUN`: the word at the program counter is fetched on every cycle in which decode accepts it.
- `FS_WAIT`: fetch is idle until a control transfer resolves.
- `FS_DONE`: fetch is idle until reset.

Its transitions are:
- RUN to WAIT when a JUMP, BNEZ or BEZ is fetched.
- RUN to DONE when END is fetched.
- WAIT to RUN on the redirect pulse from execute. This pulse loads the target when the transfer is taken and keeps the next sequential address when it is not.

Top module: `stallpipe_core`

## Requirements
- R1: Stages are fetch, decode, memory read, execute, write-back in that order. A program of N hazard-free, branch-free instructions followed by END halts with `cycle_count` N+5 and `retired_count` N+1.
- R2: LOAD copies data-memory word [5:0] into register [11:9]. STORE writes register [8:6] into data-memory word [5:0] during the memory-read stage.
- R3: ADD, SUB (A minus B, modulo 2^16), AND, OR and XOR write f(reg[8:6], reg[5:3]) into register [11:9]. There are eight 16-bit registers, all zero after reset.
- R4: Encoding: opcode [15:12] with NOP=0, LOAD=1, STORE=2, ADD=3, SUB=4, AND=5, OR=6, XOR=7, JUMP=8, BNEZ=9, BEZ=10, END=15. Destination is [11:9], source A [8:6], source B [5:3], and address/target [5:0].
- R5: A reader leaves decode no earlier than the write-back cycle of an older in-flight writer of the same register. Back-to-back dependence costs two bubbles, and one unrelated instruction in between leaves one bubble.
- R6: After a control transfer is fetched, nothing is fetched until it resolves at the end of execute. With no stall, the next instruction enters decode four cycles after the transfer did. Wrong-path instructions never execute.
- R7: JUMP always goes to [5:0]. BNEZ goes there when reg[8:6] is nonzero, BEZ when it is zero. Otherwise execution continues at the next address.
- R8: END stops fetch. `halt` rises at the clock edge that retires END and stays high. No instruction completes after it.
- R9: `cycle_count` counts edges since reset release up to and including the halting edge and then holds. `retired_count` counts instructions completing write-back, END included.
- R10: During reset `halt`, `cycle_count` and `retired_count` are 0. Memory writes from the load ports are honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; memories are loaded while it is low |
| imem_we | input | 1 | Program memory write enable |
| imem_addr | input | 6 | Program memory write address |
| imem_wdata | input | 16 | Program word to write |
| dmem_we | input | 1 | Data memory write enable (load port) |
| dmem_addr | input | 6 | Data memory address for load and read-back |
| dmem_wdata | input | 16 | Data word to write |
| dmem_rdata | output | 16 | Data memory word at `dmem_addr` |
| halt | output | 1 | High once END has retired |
| cycle_count | output | 32 | Cycles since reset release, frozen at halt |
| retired_count | output | 32 | Instructions completed, frozen at halt |

## Verification
The hardest case to reach is a conditional branch that is itself held in decode by a data dependence while fetch is already waiting on that same branch. Two stall mechanisms then overlap, and the redirect edge moves by exactly the stall length. The stimulus reaches it with a SUB that writes R2, followed directly by a BEZ on R2. The taken/not-taken choice and the skipped wrong-path stores are then checked through data-memory contents, and the overlap itself through the exact halt cycle. Separate programs cover straight-line code and chains of back-to-back and one-apart dependences, so that each delay source can be told apart in the cycle count.

// File: rtl/stallpipe_pkg.sv
package stallpipe_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned OPC_W   = 4;
    localparam int unsigned REG_W   = 3;
    localparam int unsigned MADDR_W = 6;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP   = 4'h0,
        OP_LOAD  = 4'h1,
        OP_STORE = 4'h2,
        OP_ADD   = 4'h3,
        OP_SUB   = 4'h4,
        OP_AND   = 4'h5,
        OP_OR    = 4'h6,
        OP_XOR   = 4'h7,
        OP_JUMP  = 4'h8,
        OP_BNEZ  = 4'h9,
        OP_BEZ   = 4'hA,
        OP_END   = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        FS_RUN  = 2'd0,
        FS_WAIT = 2'd1,
        FS_DONE = 2'd2
    } fetch_state_e;

    typedef struct packed {
        logic               valid;
        opcode_e            op;
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   ra;
        logic [REG_W-1:0]   rb;
        logic [MADDR_W-1:0] addr;
        logic [WORD_W-1:0]  a;
        logic [WORD_W-1:0]  b;
        logic [WORD_W-1:0]  res;
    } stage_t;

    function automatic logic op_is_alu(opcode_e op);
        return op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR};
    endfunction

    function automatic logic op_writes(opcode_e op);
        return op_is_alu(op) || (op == OP_LOAD);
    endfunction

    function automatic logic op_reads_a(opcode_e op);
        return op_is_alu(op) || op inside {OP_STORE, OP_BNEZ, OP_BEZ};
    endfunction

    function automatic logic op_reads_b(opcode_e op);
        return op_is_alu(op);
    endfunction

    function automatic logic op_is_ctrl(opcode_e op);
        return op inside {OP_JUMP, OP_BNEZ, OP_BEZ};
    endfunction

endpackage

// File: rtl/stallpipe_regfile.sv
module stallpipe_regfile
    import stallpipe_pkg::*;
#(
    parameter int unsigned NREGS = 1 << REG_W,
    parameter int unsigned DW    = WORD_W,
    parameter int unsigned IW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [IW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] regs_q [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    // write-through: a value written this cycle is visible to decode now
    assign rdata_a = (we && waddr == raddr_a) ? wdata : regs_q[raddr_a];
    assign rdata_b = (we && waddr == raddr_b) ? wdata : regs_q[raddr_b];

endmodule

// File: rtl/stallpipe_alu.sv
module stallpipe_alu
    import stallpipe_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  opcode_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);

    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/stallpipe_fetch.sv
module stallpipe_fetch
    import stallpipe_pkg::*;
#(
    parameter int unsigned AW = MADDR_W,
    parameter int unsigned DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_we,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          dec_hold,
    input  logic          redirect_valid,
    input  logic          redirect_taken,
    input  logic [AW-1:0] redirect_target,
    output logic          dec_valid,
    output logic [DW-1:0] dec_instr
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] imem [DEPTH];
    fetch_state_e  state_q, state_d;
    logic [AW-1:0] pc_q, pc_d;
    logic [DW-1:0] fetch_word;
    opcode_e       fetch_op;
    logic          take;

    assign fetch_word = imem[pc_q];
    assign fetch_op   = opcode_e'(fetch_word[DW-1 -: OPC_W]);

    always_ff @(posedge clk) begin
        if (load_we) imem[load_addr] <= load_data;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_RUN;
        else        state_q <= state_d;
    end

    // next state and program counter
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        take    = 1'b0;
        unique case (state_q)
            FS_RUN: begin
                if (!dec_hold) begin
                    take = 1'b1;
                    pc_d = pc_q + AW'(1);
                    if (op_is_ctrl(fetch_op))   state_d = FS_WAIT;
                    else if (fetch_op == OP_END) state_d = FS_DONE;
                end
            end
            FS_WAIT: begin
                if (redirect_valid) begin
                    state_d = FS_RUN;
                    if (redirect_taken) pc_d = redirect_target;
                end
            end
            FS_DONE: begin
                state_d = FS_DONE;
            end
            default: state_d = FS_RUN;
        endcase
    end

    // outputs: program counter and decode latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q      <= '0;
            dec_valid <= 1'b0;
            dec_instr <= '0;
        end else begin
            pc_q <= pc_d;
            if (!dec_hold) begin
                dec_valid <= take;
                dec_instr <= fetch_word;
            end
        end
    end

    // R6: fetch leaves the wait state right after the redirect
    assert_resume_after_resolve_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (state_q == FS_RUN));

    // R8: once END was fetched nothing more is handed to decode
    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_DONE) |=> !dec_valid);

endmodule

// File: rtl/stallpipe_core.sv
module stallpipe_core
    import stallpipe_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned AW    = MADDR_W,
    parameter int unsigned DW    = WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             imem_we,
    input  logic [AW-1:0]    imem_addr,
    input  logic [DW-1:0]    imem_wdata,
    input  logic             dmem_we,
    input  logic [AW-1:0]    dmem_addr,
    input  logic [DW-1:0]    dmem_wdata,
    output logic [DW-1:0]    dmem_rdata,
    output logic             halt,
    output logic [CNT_W-1:0] cycle_count,
    output logic [CNT_W-1:0] retired_count
);

    localparam int unsigned DDEPTH = 1 << AW;
    localparam int unsigned NREGS  = 1 << REG_W;

    // ---------------- fetch ----------------
    logic          dec_valid;
    logic [DW-1:0] dec_instr;
    logic          dec_hold;
    logic          redirect_valid, redirect_taken;
    logic [AW-1:0] redirect_target;

    stallpipe_fetch #(.AW(AW), .DW(DW)) u_fetch (
        .clk             (clk),
        .rst_n           (rst_n),
        .load_we         (imem_we),
        .load_addr       (imem_addr),
        .load_data       (imem_wdata),
        .dec_hold        (dec_hold),
        .redirect_valid  (redirect_valid),
        .redirect_taken  (redirect_taken),
        .redirect_target (redirect_target),
        .dec_valid       (dec_valid),
        .dec_instr       (dec_instr)
    );

    // ---------------- decode ----------------
    opcode_e          d_op;
    logic [REG_W-1:0] d_rd, d_ra, d_rb;
    logic [AW-1:0]    d_addr;
    logic [DW-1:0]    rf_a, rf_b;
    stage_t           mr_q, ex_q, wb_q, issue;
    logic             rf_we;
    logic             haz_a, haz_b;

    assign d_op   = opcode_e'(dec_instr[DW-1 -: OPC_W]);
    assign d_rd   = dec_instr[11:9];
    assign d_ra   = dec_instr[8:6];
    assign d_rb   = dec_instr[5:3];
    assign d_addr = dec_instr[AW-1:0];

    assign rf_we = wb_q.valid && op_writes(wb_q.op);

    stallpipe_regfile #(.NREGS(NREGS), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (wb_q.rd),
        .wdata   (wb_q.res),
        .raddr_a (d_ra),
        .rdata_a (rf_a),
        .raddr_b (d_rb),
        .rdata_b (rf_b)
    );

    function automatic logic pending(stage_t s, logic [REG_W-1:0] r);
        return s.valid && op_writes(s.op) && (s.rd == r);
    endfunction

    // writers in memory-read or execute have not reached write-back yet
    assign haz_a    = op_reads_a(d_op) && (pending(mr_q, d_ra) || pending(ex_q, d_ra));
    assign haz_b    = op_reads_b(d_op) && (pending(mr_q, d_rb) || pending(ex_q, d_rb));
    assign dec_hold = dec_valid && (haz_a || haz_b);

    always_comb begin
        issue       = '0;
        issue.valid = dec_valid && !dec_hold;
        issue.op    = d_op;
        issue.rd    = d_rd;
        issue.ra    = d_ra;
        issue.rb    = d_rb;
        issue.addr  = d_addr;
        issue.a     = rf_a;
        issue.b     = rf_b;
    end

    // ---------------- data memory ----------------
    logic [DW-1:0] dmem [DDEPTH];

    always_ff @(posedge clk) begin
        if (dmem_we)
            dmem[dmem_addr] <= dmem_wdata;
        else if (mr_q.valid && mr_q.op == OP_STORE)
            dmem[mr_q.addr] <= mr_q.a;
    end

    assign dmem_rdata = dmem[dmem_addr];

    // ---------------- execute ----------------
    logic [DW-1:0] alu_y;

    stallpipe_alu #(.DW(DW)) u_alu (
        .op (ex_q.op),
        .a  (ex_q.a),
        .b  (ex_q.b),
        .y  (alu_y)
    );

    assign redirect_valid  = ex_q.valid && op_is_ctrl(ex_q.op);
    assign redirect_target = ex_q.addr;
    always_comb begin
        unique case (ex_q.op)
            OP_JUMP: redirect_taken = 1'b1;
            OP_BNEZ: redirect_taken = (ex_q.a != '0);
            OP_BEZ:  redirect_taken = (ex_q.a == '0);
            default: redirect_taken = 1'b0;
        endcase
    end

    // ---------------- stage registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr_q <= '0;
            ex_q <= '0;
            wb_q <= '0;
        end else begin
            mr_q <= issue;
            ex_q <= mr_q;
            if (mr_q.op == OP_LOAD) ex_q.res <= dmem[mr_q.addr];
            wb_q <= ex_q;
            if (op_is_alu(ex_q.op)) wb_q.res <= alu_y;
        end
    end

    // ---------------- retire, halt and counters ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt          <= 1'b0;
            cycle_count   <= '0;
            retired_count <= '0;
        end else if (!halt) begin
            cycle_count <= cycle_count + CNT_W'(1);
            if (wb_q.valid) retired_count <= retired_count + CNT_W'(1);
            if (wb_q.valid && wb_q.op == OP_END) halt <= 1'b1;
        end
    end

    // ---------------- assertions ----------------
    logic raw_overlap;
    assign raw_overlap = mr_q.valid &&
        ((op_reads_a(mr_q.op) && (pending(ex_q, mr_q.ra) || pending(wb_q, mr_q.ra))) ||
         (op_reads_b(mr_q.op) && (pending(ex_q, mr_q.rb) || pending(wb_q, mr_q.rb))));

    // R5: a reader never trails its writer by fewer than three stages
    assert_no_raw_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_overlap);

    // R6: while a transfer is past decode, decode holds no instruction
    assert_ctrl_drains_decode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mr_q.valid && op_is_ctrl(mr_q.op)) || (ex_q.valid && op_is_ctrl(ex_q.op))) |-> !dec_valid);

    // R8: after halt the pipeline is empty
    assert_idle_after_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !(dec_valid || mr_q.valid || ex_q.valid || wb_q.valid));

    // R9: counters freeze at halt and retirements never outnumber cycles
    assert_cycle_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(cycle_count) && $stable(retired_count));

    assert_retire_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        retired_count <= cycle_count);

endmodule

// File: tb/stallpipe_core_tb_top.sv
module stallpipe_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_addr = '0;
    logic [15:0] imem_wdata = '0;
    logic        dmem_we = 1'b0;
    logic [5:0]  dmem_addr = '0;
    logic [15:0] dmem_wdata = '0;
    logic [15:0] dmem_rdata;
    logic        halt;
    logic [31:0] cycle_count, retired_count;

    always #4 clk = ~clk;   // 125 MHz

    stallpipe_core dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .imem_we       (imem_we),
        .imem_addr     (imem_addr),
        .imem_wdata    (imem_wdata),
        .dmem_we       (dmem_we),
        .dmem_addr     (dmem_addr),
        .dmem_wdata    (dmem_wdata),
        .dmem_rdata    (dmem_rdata),
        .halt          (halt),
        .cycle_count   (cycle_count),
        .retired_count (retired_count)
    );

    typedef enum int {K_MEM, K_CYC, K_RET, K_HALT} kind_e;
    typedef struct {
        kind_e kind;
        int    addr;
        int    value;
        string tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] prog_q[$];
    logic [15:0] dinit [64];
    int          checks = 0;
    int          errors = 0;
    int          halt_edge = 0;

    localparam logic [15:0] W_NOP = 16'h0000;
    localparam logic [15:0] W_END = 16'hF000;

    // R4 encodings
    function automatic logic [15:0] alu(logic [3:0] op, int rd, int ra, int rb);
        return {op, 3'(rd), 3'(ra), 3'(rb), 3'b000};
    endfunction
    function automatic logic [15:0] ld(int rd, int addr);
        return {4'h1, 3'(rd), 3'b000, 6'(addr)};
    endfunction
    function automatic logic [15:0] st(int addr, int rs);
        return {4'h2, 3'b000, 3'(rs), 6'(addr)};
    endfunction
    function automatic logic [15:0] br(logic [3:0] op, int rs, int tgt);
        return {op, 3'b000, 3'(rs), 6'(tgt)};
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_item(kind_e k, int addr, int value, string tag);
        exp_t e;
        e.kind = k; e.addr = addr; e.value = value; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor side: pops each expectation and compares with the design
    task automatic monitor_drain();
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            case (e.kind)
                K_MEM: begin
                    dmem_addr = 6'(e.addr);
                    #1;
                    check(e.tag, $sformatf("M%0d", e.addr), int'(dmem_rdata), e.value);
                end
                K_CYC:  check(e.tag, "cycle_count", int'(cycle_count), e.value);
                K_RET:  check(e.tag, "retired_count", int'(retired_count), e.value);
                K_HALT: check(e.tag, "halt edge", halt_edge, e.value);
                default: ;
            endcase
        end
    endtask

    task automatic run_program(string name);
        int edges;
        logic [31:0] c0, r0;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) begin
            imem_we    = 1'b1;
            imem_addr  = 6'(i);
            imem_wdata = (i < prog_q.size()) ? prog_q[i] : W_END;
            dmem_we    = 1'b1;
            dmem_addr  = 6'(i);
            dmem_wdata = dinit[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
        dmem_we = 1'b0;
        // R10 reset state
        check("R10", {name, " reset halt"}, int'(halt), 0);
        check("R10", {name, " reset cycle_count"}, int'(cycle_count), 0);
        check("R10", {name, " reset retired_count"}, int'(retired_count), 0);
        rst_n = 1'b1;
        edges = 0;
        while (1) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (halt) break;
            if (edges > 400) begin
                errors++;
                $display("FAIL R8 %s watchdog: actual no halt expected halt", name);
                break;
            end
        end
        halt_edge = edges;
        monitor_drain();
        // R9 counters hold after halt
        c0 = cycle_count;
        r0 = retired_count;
        repeat (4) @(negedge clk);
        check("R9", {name, " frozen cycle_count"}, int'(cycle_count), int'(c0));
        check("R9", {name, " frozen retired_count"}, int'(retired_count), int'(r0));
        check("R8", {name, " halt stays high"}, int'(halt), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL global watchdog: actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // ---- program A: straight line, every ALU op (R1 R2 R3 R4) ----
        prog_q = {};
        for (int i = 0; i < 64; i++) dinit[i] = '0;
        dinit[0] = 16'd12; dinit[1] = 16'd10; dinit[2] = 16'd7;
        prog_q.push_back(ld(1, 0));
        prog_q.push_back(ld(2, 1));
        prog_q.push_back(ld(4, 2));
        prog_q.push_back(W_NOP);
        prog_q.push_back(alu(4'h3, 3, 1, 2));
        prog_q.push_back(alu(4'h4, 5, 1, 4));
        prog_q.push_back(alu(4'h7, 6, 1, 2));
        prog_q.push_back(alu(4'h5, 7, 1, 4));
        prog_q.push_back(alu(4'h6, 0, 1, 2));
        prog_q.push_back(W_NOP);
        prog_q.push_back(st(8, 3));
        prog_q.push_back(st(9, 5));
        prog_q.push_back(st(10, 6));
        prog_q.push_back(st(11, 7));
        prog_q.push_back(st(12, 0));
        prog_q.push_back(W_END);
        expect_item(K_MEM, 8, 22, "R3 ADD");
        expect_item(K_MEM, 9, 5, "R3 SUB");
        expect_item(K_MEM, 10, 6, "R3 XOR");
        expect_item(K_MEM, 11, 4, "R3 AND");
        expect_item(K_MEM, 12, 14, "R2 R4 OR into R0");
        expect_item(K_CYC, 0, 20, "R1");
        expect_item(K_RET, 0, 16, "R1");
        expect_item(K_HALT, 0, 20, "R8");
        run_program("A");

        // ---- program B: dependence chains (R5, SUB wrap R3) ----
        prog_q = {};
        for (int i = 0; i < 64; i++) dinit[i] = '0;
        dinit[0] = 16'd9;
        prog_q.push_back(ld(1, 0));
        prog_q.push_back(alu(4'h3, 2, 1, 1));
        prog_q.push_back(alu(4'h4, 3, 0, 2));
        prog_q.push_back(W_NOP);
        prog_q.push_back(st(5, 3));
        prog_q.push_back(W_END);
        expect_item(K_MEM, 5, 65518, "R5 R3 stalled SUB wrap");
        expect_item(K_CYC, 0, 15, "R5");
        expect_item(K_RET, 0, 6, "R9");
        expect_item(K_HALT, 0, 15, "R5");
        run_program("B");

        // ---- program C: jump and branches (R6 R7) ----
        prog_q = {};
        for (int i = 0; i < 64; i++) dinit[i] = '0;
        dinit[0] = 16'd1;
        prog_q.push_back(ld(1, 0));             // 0
        prog_q.push_back(br(4'h8, 0, 4));       // 1 JUMP 4
        prog_q.push_back(st(20, 1));            // 2 wrong path
        prog_q.push_back(W_END);                // 3 wrong path
        prog_q.push_back(br(4'hA, 1, 7));       // 4 BEZ R1 not taken
        prog_q.push_back(st(21, 1));            // 5
        prog_q.push_back(br(4'h9, 1, 9));       // 6 BNEZ R1 taken
        prog_q.push_back(st(22, 1));            // 7 skipped
        prog_q.push_back(st(23, 1));            // 8 skipped
        prog_q.push_back(alu(4'h4, 2, 1, 1));   // 9 R2 = 0
        prog_q.push_back(br(4'hA, 2, 13));      // 10 BEZ R2 taken, stalled
        prog_q.push_back(st(24, 1));            // 11 skipped
        prog_q.push_back(W_END);                // 12 skipped
        prog_q.push_back(st(25, 1));            // 13
        prog_q.push_back(W_END);                // 14
        expect_item(K_MEM, 20, 0, "R6 wrong path after JUMP");
        expect_item(K_MEM, 21, 1, "R7 BEZ not taken");
        expect_item(K_MEM, 22, 0, "R7 BNEZ taken skip");
        expect_item(K_MEM, 23, 0, "R7 BNEZ taken skip");
        expect_item(K_MEM, 24, 0, "R6 stalled BEZ skip");
        expect_item(K_MEM, 25, 1, "R7 BEZ target");
        expect_item(K_CYC, 0, 27, "R6");
        expect_item(K_RET, 0, 9, "R9");
        expect_item(K_HALT, 0, 27, "R8");
        run_program("C");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule